// File: doc/BRIEF.md
# Tie-Balanced Rounding and Saturation Unit

This unit narrows a signed two's-complement fixed-point sample. It removes a fixed number of low fraction bits and rounds to the nearest value. A value that sits exactly halfway between two neighbours goes to the neighbour with an even least significant kept bit, or to the odd one when the per-sample mode bit is set. The rounded value is then clamped into a narrower output word, and a flag is raised whenever clamping changed the value. Because ties are split evenly between rounding up and rounding down, long runs of halfway values do not drift the mean of a signal path. This makes the unit suitable as the last stage after a multiply-accumulate, a filter or a mixer.

The rounding decision can be built in two ways, selected at elaboration. The first inspects the first dropped bit, an OR of the remaining dropped bits and the kept LSB directly. The second adds a bias of one half, or one half less one dropped LSB, and then patches the kept LSB when the dropped bits of the sum show the exact-midpoint pattern. Both builds give the same result for every input. The pipeline has one register stage for rounding and one for clamping, with a valid flag carried alongside the data.

Top module: `rnd_sat`

## Requirements
- R1: When the dropped fraction is not exactly one half, the output is the nearest representable value (above half rounds up, below half rounds down, toward minus infinity in two's complement).
- R2: With `modeOdd` = 0 and a dropped fraction of exactly one half, the result is the neighbour whose LSB is 0.
- R3: With `modeOdd` = 1 and a dropped fraction of exactly one half, the result is the neighbour whose LSB is 1.
- R4: Rounding is symmetric about zero on ties in both modes: a tie value and its negation give results that sum to zero.
- R5: A rounded value above the largest output value gives exactly that largest value (0 followed by all ones) with `outOvf` = 1.
- R6: A rounded value below the smallest output value gives exactly that smallest value (1 followed by all zeros) with `outOvf` = 1.
- R7: A rounded value inside the output range, including both rails reached exactly, is passed through unchanged with `outOvf` = 0.
- R8: Each sample accepted with `inValid` = 1 appears with `outValid` = 1 exactly two rising edges later; `outValid` is 0 on cycles with no sample in flight.
- R9: A synchronous reset clears both valid stages, so `outValid` is 0 on the cycle after reset is sampled, whatever `inValid` does.
- R10: `modeOdd` is taken with each sample, so consecutive samples can use different tie modes with no gap.
- R11: The direct decision build (`USE_MIDPOINT` = 0) and the bias-and-patch build (`USE_MIDPOINT` = 1) give identical `outSample` and `outOvf` for every input and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input sample present this cycle |
| inSample | input | IN_W | Signed input, DROP fraction bits at the bottom |
| modeOdd | input | 1 | Tie mode for this sample: 0 goes to even, 1 goes to odd |
| outValid | output | 1 | Output sample present this cycle |
| outSample | output | OUT_W | Rounded and clamped signed result |
| outOvf | output | 1 | Clamping changed the value of this sample |

## Verification
Every result, including the value, the overflow flag and the valid flag, is due two rising edges after the edge that took the sample. The bench records the cycle at which each sample was driven and its expected value from an integer model. On each falling edge it checks that an output present then is due in exactly that cycle, and it compares both builds against the model. Idle gaps are placed between bursts, so a valid flag that arrives early, late or from nowhere shows up as a timing miscompare.

// File: rtl/rnd_sat_pkg.sv
package rnd_sat_pkg;

  // Stage enables passed from the control to the datapath.
  typedef struct packed {
    logic advRound;   // capture a rounded value this edge
    logic advSat;     // capture a clamped value this edge
  } rsStrobe_t;

endpackage

// File: rtl/rnd_sat_ctrl.sv
module rnd_sat_ctrl
  import rnd_sat_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  output rsStrobe_t strobe,
  output logic      outValid
);

  logic vldRound;
  logic vldSat;

  always_ff @(posedge clk) begin
    if (rst) begin
      vldRound <= 1'b0;
      vldSat   <= 1'b0;
    end else begin
      vldRound <= inValid;
      vldSat   <= vldRound;
    end
  end

  always_comb begin
    strobe.advRound = inValid;
    strobe.advSat   = vldRound;
  end

  assign outValid = vldSat;

  // R8: a sample arrives two edges after it was accepted
  p_latency_r8: assert property (@(posedge clk) disable iff (rst)
    inValid |=> ##1 outValid);

  // R8: no output without a sample two edges back
  p_bubble_r8: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ##1 !outValid);

  // R9: reset empties the pipeline
  p_reset_r9: assert property (@(posedge clk)
    rst |=> !outValid);

endmodule

// File: rtl/rnd_sat_dp.sv
module rnd_sat_dp
  import rnd_sat_pkg::*;
#(
  parameter int IN_W         = 22,
  parameter int DROP         = 8,
  parameter int OUT_W        = 12,
  parameter int USE_MIDPOINT = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  rsStrobe_t        strobe,
  input  logic [IN_W-1:0]  sampleIn,
  input  logic             modeOdd,
  output logic [OUT_W-1:0] satOut,
  output logic             satOvf
);

  localparam int KEEP_W = IN_W - DROP;
  localparam int RW     = KEEP_W + 1;
  localparam int BW     = IN_W + 1;
  localparam logic [DROP-1:0] LOW_MASK = DROP'((1 << (DROP - 1)) - 1);
  localparam logic [DROP-1:0] HALF     = DROP'(1 << (DROP - 1));
  localparam logic signed [RW-1:0] RND_MAX = {{(RW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [RW-1:0] RND_MIN = {{(RW-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};
  localparam logic [OUT_W-1:0] OUT_TOP = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] OUT_BOT = {1'b1, {(OUT_W-1){1'b0}}};

  logic signed [RW-1:0] rndNext;
  logic signed [RW-1:0] rndQ;

  generate
    if (USE_MIDPOINT == 0) begin : g_direct
      logic [KEEP_W-1:0] kept;
      logic guardBit;
      logic stickyBit;
      logic bump;
      assign kept      = sampleIn[IN_W-1:DROP];
      assign guardBit  = sampleIn[DROP-1];
      assign stickyBit = |(sampleIn[DROP-1:0] & LOW_MASK);
      // Tie: bump only if the kept LSB has the wrong parity for the mode.
      assign bump      = guardBit & (stickyBit | (kept[0] ^ modeOdd));
      assign rndNext   = {kept[KEEP_W-1], kept} + RW'(bump);
    end else begin : g_midpoint
      logic [BW-1:0] biased;
      logic [RW-1:0] upper;
      logic          midHit;
      // Bias of half-minus-one-LSB, plus one more in even mode.
      assign biased = {sampleIn[IN_W-1], sampleIn} + BW'(LOW_MASK) + BW'(!modeOdd);
      assign upper  = biased[BW-1:DROP];
      assign midHit = modeOdd ? (&biased[DROP-1:0]) : ~(|biased[DROP-1:0]);
      assign rndNext = midHit ? {upper[RW-1:1], modeOdd} : upper;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobe.advRound) rndQ <= rndNext;
  end

  logic             fits;
  logic [OUT_W-1:0] satNext;

  always_comb begin
    fits    = (&rndQ[RW-1:OUT_W-1]) | ~(|rndQ[RW-1:OUT_W-1]);
    satNext = fits ? rndQ[OUT_W-1:0] : (rndQ[RW-1] ? OUT_BOT : OUT_TOP);
  end

  always_ff @(posedge clk) begin
    if (strobe.advSat) begin
      satOut <= satNext;
      satOvf <= ~fits;
    end
  end

  // R2: even-mode ties leave a 0 in the kept LSB
  p_tie_even_r2: assert property (@(posedge clk) disable iff (rst)
    (strobe.advRound && !modeOdd && sampleIn[DROP-1:0] == HALF) |=> (rndQ[0] == 1'b0));

  // R3: odd-mode ties leave a 1 in the kept LSB
  p_tie_odd_r3: assert property (@(posedge clk) disable iff (rst)
    (strobe.advRound && modeOdd && sampleIn[DROP-1:0] == HALF) |=> (rndQ[0] == 1'b1));

  // R5: clamp to the top rail
  p_pos_clamp_r5: assert property (@(posedge clk) disable iff (rst)
    (strobe.advSat && rndQ > RND_MAX) |=> (satOvf && satOut == OUT_TOP));

  // R6: clamp to the bottom rail
  p_neg_clamp_r6: assert property (@(posedge clk) disable iff (rst)
    (strobe.advSat && rndQ < RND_MIN) |=> (satOvf && satOut == OUT_BOT));

  // R7: in-range values pass unchanged
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    (strobe.advSat && rndQ <= RND_MAX && rndQ >= RND_MIN)
      |=> (!satOvf && satOut == $past(rndQ[OUT_W-1:0])));

endmodule

// File: rtl/rnd_sat.sv
module rnd_sat
  import rnd_sat_pkg::*;
#(
  parameter int IN_W         = 22,
  parameter int DROP         = 8,
  parameter int OUT_W        = 12,
  parameter int USE_MIDPOINT = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [IN_W-1:0]  inSample,
  input  logic             modeOdd,
  output logic             outValid,
  output logic [OUT_W-1:0] outSample,
  output logic             outOvf
);

  rsStrobe_t strobe;

  rnd_sat_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  rnd_sat_dp #(
    .IN_W         (IN_W),
    .DROP         (DROP),
    .OUT_W        (OUT_W),
    .USE_MIDPOINT (USE_MIDPOINT)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .sampleIn (inSample),
    .modeOdd  (modeOdd),
    .satOut   (outSample),
    .satOvf   (outOvf)
  );

endmodule

// File: tb/rnd_sat_bench.sv
module rnd_sat_bench;

  localparam int IN_W  = 22;
  localparam int DROP  = 8;
  localparam int OUT_W = 12;
  localparam int OMAX  = (1 << (OUT_W - 1)) - 1;
  localparam int OMIN  = -(1 << (OUT_W - 1));
  localparam int SCALE = 1 << DROP;
  localparam int HALFV = 1 << (DROP - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [IN_W-1:0] inSample = '0;
  logic modeOdd = 1'b0;
  logic outValid, outValidAlt;
  logic [OUT_W-1:0] outSample, outSampleAlt;
  logic outOvf, outOvfAlt;

  always #5 clk = ~clk;

  rnd_sat #(.IN_W(IN_W), .DROP(DROP), .OUT_W(OUT_W), .USE_MIDPOINT(0)) u_rnd_sat (
    .clk(clk), .rst(rst), .inValid(inValid), .inSample(inSample), .modeOdd(modeOdd),
    .outValid(outValid), .outSample(outSample), .outOvf(outOvf));

  rnd_sat #(.IN_W(IN_W), .DROP(DROP), .OUT_W(OUT_W), .USE_MIDPOINT(1)) u_rnd_sat_alt (
    .clk(clk), .rst(rst), .inValid(inValid), .inSample(inSample), .modeOdd(modeOdd),
    .outValid(outValidAlt), .outSample(outSampleAlt), .outOvf(outOvfAlt));

  int cycle = 0;
  int checks = 0;
  int fails = 0;
  int symSum = 0;
  bit finished = 0;

  int    qVal[$];
  bit    qOvf[$];
  int    qCyc[$];
  string qTag[$];
  bit    qSym[$];

  always @(posedge clk) cycle <= cycle + 1;

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, got, exp, cycle);
    end
  endtask

  // Behavioural model: floor, remainder, nearest with tie rule, then clamp.
  task automatic model(input int x, input bit odd, output int res, output bit ovf);
    int q, r;
    q = x >>> DROP;
    r = x - q * SCALE;
    if (r > HALFV) q = q + 1;
    else if (r == HALFV && ((q & 1) == (odd ? 0 : 1))) q = q + 1;
    ovf = 1'b0;
    if (q > OMAX) begin q = OMAX; ovf = 1'b1; end
    if (q < OMIN) begin q = OMIN; ovf = 1'b1; end
    res = q;
  endtask

  task automatic drive(input int x, input bit odd, input string tag, input bit sym);
    int res;
    bit ovf;
    model(x, odd, res, ovf);
    inValid  = 1'b1;
    inSample = x[IN_W-1:0];
    modeOdd  = odd;
    qVal.push_back(res);
    qOvf.push_back(ovf);
    qCyc.push_back(cycle + 2);
    qTag.push_back(tag);
    qSym.push_back(sym);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic idle(input int n);
    inValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Output monitor, away from the active edge.
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (outValid) begin
        if (qVal.size() == 0) begin
          check(1'b0, "R8 unexpected output", 1, 0);
        end else begin
          int ev, dc, got, gotAlt;
          bit eo, sy;
          string tg;
          ev = qVal.pop_front();
          eo = qOvf.pop_front();
          dc = qCyc.pop_front();
          tg = qTag.pop_front();
          sy = qSym.pop_front();
          got    = int'($signed(outSample));
          gotAlt = int'($signed(outSampleAlt));
          check(dc == cycle, "R8 output timing", cycle, dc);
          check(got == ev, {tg, " value"}, got, ev);
          check(outOvf == eo, {tg, " overflow flag"}, int'(outOvf), int'(eo));
          check(gotAlt == ev && outOvfAlt == eo && outValidAlt,
                "R11 midpoint build vs model", gotAlt, ev);
          if (sy) symSum += got;
        end
      end else begin
        check(!outValidAlt, "R11 valid mismatch between builds", int'(outValidAlt), 0);
        if (qVal.size() != 0 && qCyc[0] <= cycle)
          check(1'b0, "R8 missing output", 0, 1);
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    @(negedge clk);
    // R9: valid inputs during reset must not reach the output.
    inValid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!outValid && !outValidAlt, "R9 reset output valid", int'(outValid), 0);
    end
    inValid = 1'b0;
    rst = 1'b0;
    idle(2);
    check(!outValid, "R9 valid after reset release", int'(outValid), 0);

    // R1: near-tie and plain values, both signs.
    for (int k = -4; k <= 4; k++) begin
      drive(k * SCALE + HALFV - 1, 1'b0, "R1 below half", 1'b0);
      drive(k * SCALE + HALFV + 1, 1'b1, "R1 above half", 1'b0);
      drive(k * SCALE + 1, 1'b0, "R1 small fraction", 1'b0);
      drive(k * SCALE + SCALE - 1, 1'b1, "R1 large fraction", 1'b0);
      drive(k * SCALE, 1'b0, "R1 exact", 1'b0);
    end
    idle(3);

    // R2 and R3: exact ties in each mode.
    for (int k = -5; k <= 5; k++) drive(k * SCALE + HALFV, 1'b0, "R2 even tie", 1'b0);
    idle(2);
    for (int k = -5; k <= 5; k++) drive(k * SCALE + HALFV, 1'b1, "R3 odd tie", 1'b0);
    idle(3);

    // R4: ties mirrored about zero must cancel.
    for (int k = 0; k < 8; k++) begin
      drive(k * SCALE + HALFV, k[0], "R4 symmetric tie", 1'b1);
      drive(-(k * SCALE + HALFV), k[0], "R4 symmetric tie", 1'b1);
    end
    idle(4);
    check(symSum == 0, "R4 tie sum", symSum, 0);

    // R10: mode flips every sample on back-to-back ties.
    for (int k = 0; k < 8; k++) drive(3 * SCALE + HALFV + (k / 2) * SCALE, k[0], "R10 per-sample mode", 1'b0);
    idle(2);

    // R5 / R6 / R7: rails and just beyond.
    drive(OMAX * SCALE + HALFV - 1, 1'b0, "R7 top rail exact", 1'b0);
    drive(OMAX * SCALE + HALFV, 1'b0, "R5 tie rounds past top", 1'b0);
    drive(OMAX * SCALE + HALFV, 1'b1, "R7 odd tie holds top", 1'b0);
    drive((1 << (IN_W - 1)) - 1, 1'b0, "R5 input maximum", 1'b0);
    drive(OMIN * SCALE - HALFV, 1'b0, "R7 bottom rail tie", 1'b0);
    drive(OMIN * SCALE - HALFV, 1'b1, "R6 odd tie below bottom", 1'b0);
    drive(OMIN * SCALE - HALFV - 1, 1'b0, "R6 just below bottom", 1'b0);
    drive(-(1 << (IN_W - 1)), 1'b1, "R6 input minimum", 1'b0);
    drive(OMIN * SCALE, 1'b0, "R7 bottom rail exact", 1'b0);
    idle(3);

    // R11 with R1-R7 mixed: random values, random mode, random gaps.
    for (int n = 0; n < 400; n++) begin
      int x;
      x = int'($urandom_range(0, (1 << IN_W) - 1)) - (1 << (IN_W - 1));
      if (n % 3 == 0) x = (x & ~(SCALE - 1)) | HALFV;
      drive(x, 1'($urandom_range(0, 1)), "R11 random", 1'b0);
      if (n % 17 == 0) idle(int'($urandom_range(1, 3)));
    end
    idle(5);
    check(qVal.size() == 0, "R8 outputs drained", qVal.size(), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule